// File: doc/BRIEF.md
# RV64 Integer ALU with Bit Manipulation

A single-cycle, purely combinational integer execution unit for a 64-bit RISC-V style core. Each cycle it takes an 8-bit operation code and two operands and returns a result together with a flag that tells whether a conditional branch is taken. The unit covers bitwise logic with optional operand inversion, sign and zero extension, per-byte operations, signed and unsigned compares, minimum and maximum, addition and subtraction including scaled-add forms, logical and arithmetic shifts, single-bit manipulation, rotates and a simple counting path.

The operation code is a packed field, and neighbouring logic builds it the same way: bit 7 is the word flag, bits 6:5 the major class, bits 4:3 the subgroup and bits 2:0 the variant. Word forms work on the low 32 bits of the operands and return that 32-bit value sign-extended to the full width. Codes that are not defined produce a zero result and a clear taken flag. The block has no registers. Branch target arithmetic and operand selection are the job of the surrounding pipeline.

Top module: `rv_int_alu`

## Requirements
- R1: With op bit 7 set, a defined word operation computes on the low 32 bits of each operand, and result[63:32] equals copies of result[31]. The defined word codes are addw 0xA0, subw 0xA8, sllw 0xC0, srlw 0xCA, sraw 0xCB, rolw 0xD0, rorw 0xD8, clzw 0xE0, ctzw 0xE1 and cpopw 0xE2.
- R2: Logic codes in class 00, subgroup 00 give and 0x00, andn 0x01 (a AND NOT b), or 0x02, orn 0x03, xor 0x04 and xnor 0x05.
- R3: Extension and byte codes in class 00, subgroup 01 give sext_b 0x08, sext_h 0x09, zext_h 0x0A (upper 48 bits zero), orc_b 0x0C (each byte becomes 0xFF if it is nonzero, else 0x00) and rev8 0x0D (byte order reversed).
- R4: Compare codes give slt 0x18 and sltu 0x1A, each returning 0 or 1, and max 0x1C, min 0x1D, maxu 0x1E and minu 0x1F, each returning one of the two operands.
- R5: A code whose bits 7:3 are 00010 is a branch and returns a zero result. Bits 2:1 select the test: 00 equal, 10 signed less-than, 11 unsigned less-than, 01 never taken. Bit 0 inverts the test, which gives beq 0x10, bne 0x11, blt 0x14, bge 0x15, bltu 0x16 and bgeu 0x17.
- R6: br_taken is 0 for every code that is not a branch code.
- R7: add 0x20 and sub 0x28 work at full width. Scaled adds compute (a << n) + b with n = 1, 2, 3 for codes 0x22, 0x24 and 0x26. The odd codes 0x21, 0x23, 0x25 and 0x27 first zero-extend a[31:0].
- R8: sll 0x40, srl 0x4A and sra 0x4B shift by b[5:0]. slli_uw 0x41 shifts the zero-extended a[31:0]. The word shifts use b[4:0].
- R9: Single-bit codes take their index from b[5:0]: bclr 0x44 clears the bit, binv 0x45 flips it, bset 0x46 sets it and bext 0x47 returns it as 0 or 1.
- R10: rol 0x50 and ror 0x58 rotate all 64 bits by b[5:0]. rolw and rorw rotate the low 32 bits by b[4:0].
- R11: clz 0x60, ctz 0x61 and cpop 0x62 count leading zeros, trailing zeros and set bits of a. A zero input gives 64 for clz and ctz, and 32 for the word forms.
- R12: Every other code, including word codes in classes 00 and the word forms of scaled-add, slli_uw and single-bit codes, returns zero with br_taken 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_code | input | 8 | Packed operation: word flag, class, subgroup, variant |
| src_a | input | 64 | First operand |
| src_b | input | 64 | Second operand, also the shift amount or bit index |
| result | output | 64 | Operation result |
| br_taken | output | 1 | Branch condition met (branch codes only) |

## Verification
The assertions assume that op_code and both operands are fully known two-state values that stay stable while the combinational result is sampled. With no clock inside the block, they check each settled input combination on its own. The stimulus drives every one of the 256 operation codes, including all undefined ones, from a fixed seed. Each code is crossed with sign-bit, all-ones and 32-bit-boundary operands and with small shift amounts, so every input stays a defined value and each assertion premise is reached.

// File: rtl/rvalu_pkg.sv
package rvalu_pkg;

   localparam int OP_W   = 8;
   localparam int WORD_W = 32;

   typedef enum logic [1:0] {
      CLS_MISC  = 2'b00,
      CLS_ADD   = 2'b01,
      CLS_SHIFT = 2'b10,
      CLS_COUNT = 2'b11
   } op_class_e;

   typedef enum logic [1:0] {
      BR_EQ  = 2'b00,
      BR_NONE = 2'b01,
      BR_LT  = 2'b10,
      BR_LTU = 2'b11
   } br_kind_e;

   typedef struct packed {
      logic       word;
      op_class_e  cls;
      logic [1:0] sub;
      logic [2:0] vnt;
   } alu_op_t;

endpackage

// File: rtl/rvalu_misc.sv
module rvalu_misc
   import rvalu_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic            op_word,
   input  logic [1:0]      op_sub,
   input  logic [2:0]      op_vnt,
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   output logic [XLEN-1:0] res,
   output logic            hit,
   output logic            taken
);
   localparam int NBYTE = XLEN / 8;

   logic [XLEN-1:0] orc_v;
   logic [XLEN-1:0] rev_v;
   logic [XLEN-1:0] b_opt;
   logic            eq_v;
   logic            lt_s;
   logic            lt_u;
   logic            cond;
   br_kind_e        kind;

   for (genvar gi = 0; gi < NBYTE; gi++) begin : g_byte
      assign orc_v[gi*8 +: 8] = {8{|a[gi*8 +: 8]}};
      assign rev_v[gi*8 +: 8] = a[(NBYTE-1-gi)*8 +: 8];
   end

   assign b_opt = op_vnt[0] ? ~b : b;
   assign eq_v  = (a == b);
   assign lt_s  = ($signed(a) < $signed(b));
   assign lt_u  = (a < b);
   assign kind  = br_kind_e'(op_vnt[2:1]);

   always_comb begin
      case (kind)
         BR_EQ:   cond = eq_v;
         BR_LT:   cond = lt_s;
         BR_LTU:  cond = lt_u;
         default: cond = 1'b0;
      endcase
   end

   always_comb begin
      res   = '0;
      hit   = 1'b0;
      taken = 1'b0;
      if (!op_word) begin
         case (op_sub)
            2'b00: begin
               hit = 1'b1;
               case (op_vnt[2:1])
                  2'b00:   res = a & b_opt;
                  2'b01:   res = a | b_opt;
                  2'b10:   res = a ^ b_opt;
                  default: hit = 1'b0;
               endcase
            end
            2'b01: begin
               hit = 1'b1;
               case (op_vnt)
                  3'b000:  res = {{(XLEN-8){a[7]}}, a[7:0]};
                  3'b001:  res = {{(XLEN-16){a[15]}}, a[15:0]};
                  3'b010:  res = {{(XLEN-16){1'b0}}, a[15:0]};
                  3'b100:  res = orc_v;
                  3'b101:  res = rev_v;
                  default: hit = 1'b0;
               endcase
            end
            2'b10: begin
               hit   = 1'b1;
               taken = (kind != BR_NONE) && (cond ^ op_vnt[0]);
            end
            default: begin
               hit = 1'b1;
               case (op_vnt)
                  3'b000:  res = {{(XLEN-1){1'b0}}, lt_s};
                  3'b010:  res = {{(XLEN-1){1'b0}}, lt_u};
                  3'b100:  res = lt_s ? b : a;
                  3'b101:  res = lt_s ? a : b;
                  3'b110:  res = lt_u ? b : a;
                  3'b111:  res = lt_u ? a : b;
                  default: hit = 1'b0;
               endcase
            end
         endcase
      end
   end
endmodule

// File: rtl/rvalu_arith.sv
module rvalu_arith
   import rvalu_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic            op_word,
   input  logic [1:0]      op_sub,
   input  logic [2:0]      op_vnt,
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   output logic [XLEN-1:0] res,
   output logic            hit
);
   logic [XLEN-1:0]   a_uw;
   logic [XLEN-1:0]   a_src;
   logic [XLEN-1:0]   sh_add;
   logic [XLEN-1:0]   diff;
   logic [WORD_W-1:0] sum_w;
   logic [WORD_W-1:0] diff_w;

   assign a_uw   = {{(XLEN-WORD_W){1'b0}}, a[WORD_W-1:0]};
   assign a_src  = op_vnt[0] ? a_uw : a;
   assign sh_add = (a_src << op_vnt[2:1]) + b;
   assign diff   = a - b;
   assign sum_w  = a[WORD_W-1:0] + b[WORD_W-1:0];
   assign diff_w = a[WORD_W-1:0] - b[WORD_W-1:0];

   always_comb begin
      res = '0;
      hit = 1'b0;
      case (op_sub)
         2'b00: begin
            if (op_word) begin
               hit = (op_vnt == 3'b000);
               res = {{(XLEN-WORD_W){1'b0}}, sum_w};
            end else begin
               hit = 1'b1;
               res = sh_add;
            end
         end
         2'b01: begin
            hit = (op_vnt == 3'b000);
            res = op_word ? {{(XLEN-WORD_W){1'b0}}, diff_w} : diff;
         end
         default: hit = 1'b0;
      endcase
   end
endmodule

// File: rtl/rvalu_shift.sv
module rvalu_shift
   import rvalu_pkg::*;
#(
   parameter int XLEN = 64,
   parameter int SHW  = $clog2(XLEN)
) (
   input  logic            op_word,
   input  logic [1:0]      op_sub,
   input  logic [2:0]      op_vnt,
   input  logic [XLEN-1:0] a,
   input  logic [SHW-1:0]  shamt,
   output logic [XLEN-1:0] res,
   output logic            hit
);
   localparam int WSHW = $clog2(WORD_W);

   logic [WSHW-1:0]     sh_w;
   logic [XLEN-1:0]     a_uw;
   logic [XLEN-1:0]     bit_mask;
   logic [2*XLEN-1:0]   dbl_l;
   logic [2*XLEN-1:0]   dbl_r;
   logic [WORD_W-1:0]   a_w;
   logic [2*WORD_W-1:0] dw_l;
   logic [2*WORD_W-1:0] dw_r;
   logic [XLEN-1:0]     sra_v;
   logic [WORD_W-1:0]   sra_w;

   assign sh_w     = shamt[WSHW-1:0];
   assign a_w      = a[WORD_W-1:0];
   assign a_uw     = {{(XLEN-WORD_W){1'b0}}, a_w};
   assign bit_mask = {{(XLEN-1){1'b0}}, 1'b1} << shamt;
   assign dbl_l    = {a, a} << shamt;
   assign dbl_r    = {a, a} >> shamt;
   assign dw_l     = {a_w, a_w} << sh_w;
   assign dw_r     = {a_w, a_w} >> sh_w;
   assign sra_v    = $signed(a) >>> shamt;
   assign sra_w    = $signed(a_w) >>> sh_w;

   always_comb begin
      res = '0;
      hit = 1'b0;
      case (op_sub)
         2'b00: begin
            if (op_word) begin
               hit = (op_vnt == 3'b000);
               res = {{(XLEN-WORD_W){1'b0}}, a_w << sh_w};
            end else begin
               hit = 1'b1;
               case (op_vnt)
                  3'b000:  res = a << shamt;
                  3'b001:  res = a_uw << shamt;
                  3'b100:  res = a & ~bit_mask;
                  3'b101:  res = a ^ bit_mask;
                  3'b110:  res = a | bit_mask;
                  3'b111:  res = {{(XLEN-1){1'b0}}, |(a & bit_mask)};
                  default: hit = 1'b0;
               endcase
            end
         end
         2'b01: begin
            hit = 1'b1;
            case (op_vnt)
               3'b010:  res = op_word ? {{(XLEN-WORD_W){1'b0}}, a_w >> sh_w} : (a >> shamt);
               3'b011:  res = op_word ? {{(XLEN-WORD_W){1'b0}}, sra_w} : sra_v;
               default: hit = 1'b0;
            endcase
         end
         2'b10: begin
            hit = (op_vnt == 3'b000);
            res = op_word ? {{(XLEN-WORD_W){1'b0}}, dw_l[2*WORD_W-1:WORD_W]}
                          : dbl_l[2*XLEN-1:XLEN];
         end
         default: begin
            hit = (op_vnt == 3'b000);
            res = op_word ? {{(XLEN-WORD_W){1'b0}}, dw_r[WORD_W-1:0]}
                          : dbl_r[XLEN-1:0];
         end
      endcase
   end
endmodule

// File: rtl/rvalu_count.sv
module rvalu_count
   import rvalu_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic            op_word,
   input  logic [1:0]      op_sub,
   input  logic [2:0]      op_vnt,
   input  logic [XLEN-1:0] a,
   output logic [XLEN-1:0] res,
   output logic            hit
);
   localparam int CW = $clog2(XLEN) + 1;

   logic [XLEN-1:0] lead_in;
   logic [XLEN-1:0] trail_in;
   logic [XLEN-1:0] pop_in;
   logic [CW-1:0]   n_lead;
   logic [CW-1:0]   n_trail;
   logic [CW-1:0]   n_pop;

   // Word forms pad with ones so a zero word stops the count at 32.
   assign lead_in  = op_word ? {a[WORD_W-1:0], {(XLEN-WORD_W){1'b1}}} : a;
   assign trail_in = op_word ? {{(XLEN-WORD_W){1'b1}}, a[WORD_W-1:0]} : a;
   assign pop_in   = op_word ? {{(XLEN-WORD_W){1'b0}}, a[WORD_W-1:0]} : a;

   always_comb begin
      logic stop;
      n_lead = '0;
      stop   = 1'b0;
      for (int i = XLEN - 1; i >= 0; i--) begin
         if (!stop) begin
            if (lead_in[i]) stop = 1'b1;
            else            n_lead = n_lead + 1'b1;
         end
      end
   end

   always_comb begin
      logic stop;
      n_trail = '0;
      stop    = 1'b0;
      for (int i = 0; i < XLEN; i++) begin
         if (!stop) begin
            if (trail_in[i]) stop = 1'b1;
            else             n_trail = n_trail + 1'b1;
         end
      end
   end

   always_comb begin
      n_pop = '0;
      for (int i = 0; i < XLEN; i++) n_pop = n_pop + CW'(pop_in[i]);
   end

   always_comb begin
      res = '0;
      hit = (op_sub == 2'b00);
      case (op_vnt)
         3'b000:  res = {{(XLEN-CW){1'b0}}, n_lead};
         3'b001:  res = {{(XLEN-CW){1'b0}}, n_trail};
         3'b010:  res = {{(XLEN-CW){1'b0}}, n_pop};
         default: hit = 1'b0;
      endcase
   end
endmodule

// File: rtl/rv_int_alu.sv
module rv_int_alu
   import rvalu_pkg::*;
#(
   parameter int XLEN     = 64,
   parameter bit COUNT_EN = 1'b1
) (
   input  logic [OP_W-1:0] op_code,
   input  logic [XLEN-1:0] src_a,
   input  logic [XLEN-1:0] src_b,
   output logic [XLEN-1:0] result,
   output logic            br_taken
);
   localparam int SHW = $clog2(XLEN);

   if (XLEN < 64 || (XLEN & (XLEN - 1)) != 0) begin : g_bad_xlen
      $error("rv_int_alu: XLEN must be a power of two of at least 64");
   end

   alu_op_t         dec;
   logic [XLEN-1:0] misc_res, add_res, shf_res, cnt_res;
   logic            misc_hit, add_hit, shf_hit, cnt_hit;
   logic            misc_taken;
   logic [XLEN-1:0] sel_res;
   logic            sel_hit;
   logic [XLEN-1:0] raw;

   assign dec = alu_op_t'(op_code);

   rvalu_misc #(.XLEN(XLEN)) u_misc (
      .op_word(dec.word), .op_sub(dec.sub), .op_vnt(dec.vnt),
      .a(src_a), .b(src_b),
      .res(misc_res), .hit(misc_hit), .taken(misc_taken)
   );

   rvalu_arith #(.XLEN(XLEN)) u_arith (
      .op_word(dec.word), .op_sub(dec.sub), .op_vnt(dec.vnt),
      .a(src_a), .b(src_b),
      .res(add_res), .hit(add_hit)
   );

   rvalu_shift #(.XLEN(XLEN), .SHW(SHW)) u_shift (
      .op_word(dec.word), .op_sub(dec.sub), .op_vnt(dec.vnt),
      .a(src_a), .shamt(src_b[SHW-1:0]),
      .res(shf_res), .hit(shf_hit)
   );

   if (COUNT_EN) begin : g_count
      rvalu_count #(.XLEN(XLEN)) u_count (
         .op_word(dec.word), .op_sub(dec.sub), .op_vnt(dec.vnt),
         .a(src_a),
         .res(cnt_res), .hit(cnt_hit)
      );
   end else begin : g_no_count
      assign cnt_res = '0;
      assign cnt_hit = 1'b0;
   end

   always_comb begin
      case (dec.cls)
         CLS_MISC:  begin sel_res = misc_res; sel_hit = misc_hit; end
         CLS_ADD:   begin sel_res = add_res;  sel_hit = add_hit;  end
         CLS_SHIFT: begin sel_res = shf_res;  sel_hit = shf_hit;  end
         default:   begin sel_res = cnt_res;  sel_hit = cnt_hit;  end
      endcase
   end

   assign raw      = sel_hit ? sel_res : '0;
   assign result   = dec.word ? {{(XLEN-WORD_W){raw[WORD_W-1]}}, raw[WORD_W-1:0]} : raw;
   assign br_taken = (dec.cls == CLS_MISC) && misc_taken;
endmodule

// File: rtl/rvalu_chk.sv
module rvalu_chk #(
   parameter int XLEN = 64
) (
   input logic [7:0]      op_code,
   input logic [XLEN-1:0] src_a,
   input logic [XLEN-1:0] src_b,
   input logic [XLEN-1:0] result,
   input logic            br_taken
);
   always_comb begin
      if (op_code[7]) begin
         p_word_sext_r1: assert (result[XLEN-1:32] == {(XLEN-32){result[31]}})
            else $error("word result not sign-extended");
      end
      if (op_code == 8'h0A) begin
         p_zext_h_upper_r3: assert (result[XLEN-1:16] == '0)
            else $error("zext_h upper bits set");
      end
      if (op_code == 8'h18 || op_code == 8'h1A) begin
         p_cmp_bool_r4: assert (result[XLEN-1:1] == '0)
            else $error("set-less-than not boolean");
      end
      if (op_code[7:2] == 6'b000111) begin
         p_minmax_operand_r4: assert (result == src_a || result == src_b)
            else $error("min/max returned neither operand");
      end
      if (op_code[7:3] == 5'b00010) begin
         p_branch_res_zero_r5: assert (result == '0)
            else $error("branch code produced a result");
      end else begin
         p_taken_only_branch_r6: assert (!br_taken)
            else $error("taken flag on non-branch code");
      end
      if (op_code == 8'h47) begin
         p_bext_bool_r9: assert (result[XLEN-1:1] == '0)
            else $error("bext not boolean");
      end
      if (op_code[6:5] == 2'b11) begin
         p_count_range_r11: assert (result <= XLEN)
            else $error("count above width");
      end
      if (op_code[7:5] == 3'b100) begin
         p_word_misc_zero_r12: assert (result == '0 && !br_taken)
            else $error("undefined word code not zero");
      end
   end
endmodule

bind rv_int_alu rvalu_chk #(.XLEN(XLEN)) u_chk (
   .op_code(op_code),
   .src_a(src_a),
   .src_b(src_b),
   .result(result),
   .br_taken(br_taken)
);

// File: tb/sim_rv_int_alu.sv
module sim_rv_int_alu;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  op_code = '0;
   logic [63:0] src_a = '0;
   logic [63:0] src_b = '0;
   logic [63:0] result;
   logic        br_taken;
   int          n_cmp = 0;
   int          n_bad = 0;
   bit          done = 1'b0;

   always #4 clk = ~clk;

   rv_int_alu u0 (
      .op_code(op_code), .src_a(src_a), .src_b(src_b),
      .result(result), .br_taken(br_taken)
   );

   function automatic logic [63:0] sx32(input logic [31:0] v);
      return {{32{v[31]}}, v};
   endfunction

   function automatic logic [63:0] lead_zeros(input logic [63:0] v, input int n);
      int c = 0;
      for (int i = n - 1; i >= 0; i--) begin
         if (v[i]) break;
         c++;
      end
      return 64'(c);
   endfunction

   function automatic logic [63:0] trail_zeros(input logic [63:0] v, input int n);
      int c = 0;
      for (int i = 0; i < n; i++) begin
         if (v[i]) break;
         c++;
      end
      return 64'(c);
   endfunction

   function automatic logic [63:0] ones(input logic [63:0] v, input int n);
      int c = 0;
      for (int i = 0; i < n; i++) c += int'(v[i]);
      return 64'(c);
   endfunction

   function automatic void model(input logic [7:0] op, input logic [63:0] a, input logic [63:0] b,
                                 output logic [63:0] r, output logic t, output string tag);
      logic [63:0] az = {32'h0, a[31:0]};
      int          s  = int'(b[5:0]);
      int          s5 = int'(b[4:0]);
      logic [31:0] w;
      r = '0; t = 1'b0; tag = "R12";
      case (op)
         8'h00: begin r = a & b;    tag = "R2"; end
         8'h01: begin r = a & ~b;   tag = "R2"; end
         8'h02: begin r = a | b;    tag = "R2"; end
         8'h03: begin r = a | ~b;   tag = "R2"; end
         8'h04: begin r = a ^ b;    tag = "R2"; end
         8'h05: begin r = ~(a ^ b); tag = "R2"; end
         8'h08: begin r = {{56{a[7]}}, a[7:0]};   tag = "R3"; end
         8'h09: begin r = {{48{a[15]}}, a[15:0]}; tag = "R3"; end
         8'h0A: begin r = {48'h0, a[15:0]};       tag = "R3"; end
         8'h0C: begin
            for (int k = 0; k < 8; k++) r[k*8 +: 8] = (a[k*8 +: 8] != 0) ? 8'hFF : 8'h00;
            tag = "R3";
         end
         8'h0D: begin
            for (int k = 0; k < 8; k++) r[k*8 +: 8] = a[(7-k)*8 +: 8];
            tag = "R3";
         end
         8'h10: begin t = (a == b);  tag = "R5"; end
         8'h11: begin t = (a != b);  tag = "R5"; end
         8'h14: begin t = ($signed(a) < $signed(b));  tag = "R5"; end
         8'h15: begin t = ($signed(a) >= $signed(b)); tag = "R5"; end
         8'h16: begin t = (a < b);   tag = "R5"; end
         8'h17: begin t = (a >= b);  tag = "R5"; end
         8'h18: begin r = 64'($signed(a) < $signed(b)); tag = "R4"; end
         8'h1A: begin r = 64'(a < b); tag = "R4"; end
         8'h1C: begin r = ($signed(a) > $signed(b)) ? a : b; tag = "R4"; end
         8'h1D: begin r = ($signed(a) < $signed(b)) ? a : b; tag = "R4"; end
         8'h1E: begin r = (a > b) ? a : b; tag = "R4"; end
         8'h1F: begin r = (a < b) ? a : b; tag = "R4"; end
         8'h20: begin r = a + b;          tag = "R7"; end
         8'h21: begin r = az + b;         tag = "R7"; end
         8'h22: begin r = (a << 1) + b;   tag = "R7"; end
         8'h23: begin r = (az << 1) + b;  tag = "R7"; end
         8'h24: begin r = (a << 2) + b;   tag = "R7"; end
         8'h25: begin r = (az << 2) + b;  tag = "R7"; end
         8'h26: begin r = (a << 3) + b;   tag = "R7"; end
         8'h27: begin r = (az << 3) + b;  tag = "R7"; end
         8'h28: begin r = a - b;          tag = "R7"; end
         8'h40: begin r = a << s;         tag = "R8"; end
         8'h41: begin r = az << s;        tag = "R8"; end
         8'h4A: begin r = a >> s;         tag = "R8"; end
         8'h4B: begin r = $signed(a) >>> s; tag = "R8"; end
         8'h44: begin r = a; r[s] = 1'b0;  tag = "R9"; end
         8'h45: begin r = a; r[s] = ~a[s]; tag = "R9"; end
         8'h46: begin r = a; r[s] = 1'b1;  tag = "R9"; end
         8'h47: begin r = 64'(a[s]);       tag = "R9"; end
         8'h50: begin r = (s == 0) ? a : ((a << s) | (a >> (64 - s))); tag = "R10"; end
         8'h58: begin r = (s == 0) ? a : ((a >> s) | (a << (64 - s))); tag = "R10"; end
         8'h60: begin r = lead_zeros(a, 64);  tag = "R11"; end
         8'h61: begin r = trail_zeros(a, 64); tag = "R11"; end
         8'h62: begin r = ones(a, 64);        tag = "R11"; end
         8'hA0: begin w = a[31:0] + b[31:0]; r = sx32(w); tag = "R1"; end
         8'hA8: begin w = a[31:0] - b[31:0]; r = sx32(w); tag = "R1"; end
         8'hC0: begin w = a[31:0] << s5; r = sx32(w); tag = "R8"; end
         8'hCA: begin w = a[31:0] >> s5; r = sx32(w); tag = "R8"; end
         8'hCB: begin w = $signed(a[31:0]) >>> s5; r = sx32(w); tag = "R8"; end
         8'hD0: begin
            w = (s5 == 0) ? a[31:0] : ((a[31:0] << s5) | (a[31:0] >> (32 - s5)));
            r = sx32(w); tag = "R10";
         end
         8'hD8: begin
            w = (s5 == 0) ? a[31:0] : ((a[31:0] >> s5) | (a[31:0] << (32 - s5)));
            r = sx32(w); tag = "R10";
         end
         8'hE0: begin r = lead_zeros({32'h0, a[31:0]}, 32);  tag = "R11"; end
         8'hE1: begin r = trail_zeros({32'h0, a[31:0]}, 32); tag = "R11"; end
         8'hE2: begin r = ones({32'h0, a[31:0]}, 32);        tag = "R11"; end
         default: begin r = '0; t = 1'b0; tag = "R12"; end
      endcase
      // R6: non-branch codes never raise the taken flag.
      if (op[7:3] != 5'b00010 && t) tag = "R6";
   endfunction

   task automatic run_one(input logic [7:0] op, input logic [63:0] a, input logic [63:0] b);
      logic [63:0] exp_r;
      logic        exp_t;
      string       tag;
      @(posedge clk);
      op_code = op; src_a = a; src_b = b;
      model(op, a, b, exp_r, exp_t, tag);
      @(negedge clk);
      n_cmp++;
      if (result !== exp_r || br_taken !== exp_t) begin
         n_bad++;
         $display("FAIL %s op=%02h a=%h b=%h actual=%h/%b expected=%h/%b",
                  tag, op, a, b, result, br_taken, exp_r, exp_t);
      end
   endtask

   logic [63:0] corner [10] = '{
      64'h0, '1, 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF,
      64'h0000_0000_FFFF_FFFF, 64'h0000_0000_8000_0000, 64'hFFFF_FFFF_7FFF_FFFF,
      64'h0000_0001_0000_0000, 64'd33, 64'd31
   };

   initial begin
      void'($urandom(32'd20240611));
      repeat (4) @(posedge clk);
      rst_n = 1'b1;
      // Idle state after reset: and of zeros (R2), no taken flag (R6).
      run_one(8'h00, 64'h0, 64'h0);
      for (int op = 0; op < 256; op++) begin
         for (int i = 0; i < 10; i++)
            for (int j = 0; j < 10; j++)
               run_one(8'(op), corner[i], corner[j]);
         for (int k = 0; k < 16; k++)
            run_one(8'(op), {$urandom, $urandom}, {$urandom, $urandom});
      end
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_bad++;
         $display("FAIL watchdog all-requirements actual=timeout expected=completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule